// File: doc/BRIEF.md
# Virtual-Channel Crossbar Switch with Time-Shared Output Paths

This block joins four source ports to four sink ports. Each sink port leads to two virtual channels, so there are eight channel queues in total. Those queues sit outside the block. The switch sees each queue only through a full flag and an empty flag, and it drives one write strobe and one flit bus per queue. Packets are sequences of flits. An input that holds no channel treats its next flit as a header and routes it by the destination field presented with it. Later flits follow the channel that the header was given, until a flit marked as last has passed.

Each sink port has one write path per cycle. The inputs share that path in time, and a round-robin arbiter per sink port picks the input that advances in each cycle. The arbiter only considers an input whose path is usable. A header needs a free channel on its target port. A continuing packet needs its own channel to have room. A coordinator keeps the ownership of every channel and maps each granted header onto the lowest-numbered free channel of its port. From the ownership and the two status flags, each channel is classified as idle, empty, ready or busy.

A stalled input keeps its flit and its request asserted until it is granted. Every granted flit reaches its queue's write port one clock edge after the grant.

Top module: `tdm_vc_xbar`

## Requirements
- R1: After reset no channel is owned and every vc_wr_en bit is low. in_stall is low on every input whose in_valid is low, and no input is granted without in_valid.
- R2: A flit accepted in a cycle (in_valid high, in_stall low) appears on its channel's vc_wr_en bit and vc_wr_data slice after exactly one clock edge. A channel that is not written in a cycle has its vc_wr_en bit low in the following cycle.
- R3: An input that owns no channel treats its flit as a header bound for sink port in_dest. The header is written to channel port*2+lane, where the lane is the lowest one whose channel is idle. A channel is idle when it is unowned and its vc_empty flag is high.
- R4: After a header without in_eop is granted, the channel is locked to that input. Later flits go to that channel whatever in_dest carries. The lock ends when a flit with in_eop is granted, and the channel is idle again from the next cycle if vc_empty is high.
- R5: A header whose port has no idle channel is stalled (in_stall high) and stays pending. A channel owned by one input is never given to another input's header.
- R6: An owned channel whose vc_full is high is busy, and its owner is stalled. vc_full must already count a write presented on vc_wr_en. An owned channel with vc_full low (empty or ready) accepts a flit.
- R7: Each sink port takes at most one flit per cycle, so at most one of its two channels is written. Inputs bound for different ports advance in the same cycle.
- R8: Each port has a round-robin pointer that starts at input 0 after reset. The grant goes to the first requesting input at or after the pointer, and the pointer then moves to the input after the one granted. An output with any request grants one.
- R9: A header flit that also carries in_eop is written to an idle channel and leaves that channel unowned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 4 | Flit present, one bit per input |
| in_eop | input | 4 | Flit is the last of its packet |
| in_dest | input | 8 | Sink port of a header, 2 bits per input (input i at [2i+1:2i]) |
| in_flit | input | 32 | Flit data, 8 bits per input (input i at [8i+7:8i]) |
| in_stall | output | 4 | Flit not taken this cycle, hold it |
| vc_full | input | 8 | Channel queue cannot take another write (channel c = port*2+lane) |
| vc_empty | input | 8 | Channel queue holds no flit |
| vc_wr_en | output | 8 | Write strobe per channel |
| vc_wr_data | output | 64 | Flit per channel, 8 bits each (channel c at [8c+7:8c]) |

## Verification
Stale ownership shows within one cycle. A channel left locked after its tail makes the next header to that port land on the other lane or stall. A lost lock shows as the second flit of a packet on a different write strobe. A pointer that does not advance appears as the same input id in consecutive flits on a contended channel, from the second contended cycle on. A busy or blocked path that is still granted shows as a strobe on a full or foreign channel at the very next edge.

// File: rtl/tdm_xbar_pkg.sv
package tdm_xbar_pkg;

  typedef enum logic [1:0] {
    VC_IDLE  = 2'd0,
    VC_EMPTY = 2'd1,
    VC_READY = 2'd2,
    VC_BUSY  = 2'd3
  } vc_state_e;

  // Classify one channel from its ownership and the queue status flags.
  function automatic vc_state_e vc_classify(input logic owned, input logic full, input logic empty);
    if (!owned) return empty ? VC_IDLE : VC_BUSY;
    if (full)   return VC_BUSY;
    return empty ? VC_EMPTY : VC_READY;
  endfunction

  function automatic int vc_slot(input int port, input int lane, input int lanes);
    return port * lanes + lane;
  endfunction

  function automatic int vc_port_of(input int vc, input int lanes);
    return vc / lanes;
  endfunction

  function automatic int rr_next(input int idx, input int n);
    return (idx + 1) % n;
  endfunction

endpackage

// File: rtl/tdm_rr_arbiter.sv
module tdm_rr_arbiter
  import tdm_xbar_pkg::*;
#(
  parameter int N = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] win;
  logic [PW-1:0] idx_c;
  logic          gnt_any;

  always_comb begin
    gnt     = '0;
    gnt_any = 1'b0;
    win     = '0;
    idx_c   = '0;
    for (int s = 0; s < N; s++) begin
      idx_c = PW'((int'(ptr_q) + s) % N);
      if (!gnt_any && req[idx_c]) begin
        gnt_any = 1'b1;
        win     = idx_c;
      end
    end
    if (gnt_any) gnt[win] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr_q <= '0;
    else if (gnt_any) ptr_q <= PW'(rr_next(int'(win), N));
  end

  p_one_grant_r7: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  p_grant_has_req_r8: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req) == '0);
  p_work_conserving_r8: assert property (@(posedge clk) disable iff (!rst_n) (|req) |-> (|gnt));

endmodule

// File: rtl/tdm_vc_coord.sv
module tdm_vc_coord
  import tdm_xbar_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int VCS   = 2,
  localparam int VC_N  = N_OUT * VCS,
  localparam int VC_W  = (VC_N > 1) ? $clog2(VC_N) : 1,
  localparam int DST_W = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int LN_W  = (VCS > 1) ? $clog2(VCS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_IN-1:0]         in_valid,
  input  logic [N_IN-1:0]         in_eop,
  input  logic [N_IN*DST_W-1:0]   in_dest,
  input  logic [VC_N-1:0]         vc_full,
  input  logic [VC_N-1:0]         vc_empty,
  input  logic [N_IN-1:0]         fire,
  output logic [N_OUT*N_IN-1:0]   req_mat,
  output logic [N_IN*VC_W-1:0]    tgt_vc
);

  logic [VC_N-1:0] owned_q;
  logic [N_IN-1:0] held_q;
  logic [VC_W-1:0] held_vc_q [N_IN];

  vc_state_e       st [VC_N];
  logic [N_OUT-1:0] path_free;
  logic [LN_W-1:0]  free_lane [N_OUT];
  logic [DST_W-1:0] port_c [N_IN];
  logic [VC_W-1:0]  tgt_c [N_IN];
  logic [N_IN-1:0]  want_c;

  // Channel states and per-port availability (lowest idle lane wins).
  always_comb begin
    for (int v = 0; v < VC_N; v++) st[v] = vc_classify(owned_q[v], vc_full[v], vc_empty[v]);
    for (int o = 0; o < N_OUT; o++) begin
      path_free[o] = 1'b0;
      free_lane[o] = '0;
      for (int k = VCS - 1; k >= 0; k--) begin
        if (st[vc_slot(o, k, VCS)] == VC_IDLE) begin
          path_free[o] = 1'b1;
          free_lane[o] = LN_W'(k);
        end
      end
    end
  end

  // Per-input request: continue a locked packet or open a new one.
  always_comb begin
    req_mat = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (held_q[i]) begin
        tgt_c[i]  = held_vc_q[i];
        port_c[i] = DST_W'(vc_port_of(int'(held_vc_q[i]), VCS));
        want_c[i] = (st[held_vc_q[i]] != VC_BUSY);
      end else begin
        port_c[i] = in_dest[i*DST_W +: DST_W];
        tgt_c[i]  = VC_W'(vc_slot(int'(port_c[i]), int'(free_lane[port_c[i]]), VCS));
        want_c[i] = path_free[port_c[i]];
      end
      tgt_vc[i*VC_W +: VC_W] = tgt_c[i];
      for (int o = 0; o < N_OUT; o++)
        req_mat[o*N_IN + i] = in_valid[i] && want_c[i] && (port_c[i] == DST_W'(o));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owned_q <= '0;
      held_q  <= '0;
      for (int i = 0; i < N_IN; i++) held_vc_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_IN; i++) begin
        if (fire[i]) begin
          if (held_q[i]) begin
            if (in_eop[i]) begin
              owned_q[held_vc_q[i]] <= 1'b0;
              held_q[i]             <= 1'b0;
            end
          end else if (!in_eop[i]) begin
            owned_q[tgt_c[i]] <= 1'b1;
            held_q[i]         <= 1'b1;
            held_vc_q[i]      <= tgt_c[i];
          end
        end
      end
    end
  end

  for (genvar gi = 0; gi < N_IN; gi++) begin : g_chk
    p_held_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
      held_q[gi] |-> owned_q[held_vc_q[gi]]);
    p_tail_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fire[gi] && in_eop[gi]) |=> !held_q[gi]);
    p_lock_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (held_q[gi] && !(fire[gi] && in_eop[gi])) |=> (held_q[gi] && $stable(held_vc_q[gi])));
  end

endmodule

// File: rtl/tdm_xbar_path.sv
module tdm_xbar_path #(
  parameter int N_IN   = 4,
  parameter int VC_N   = 8,
  parameter int FLIT_W = 8,
  localparam int VC_W  = (VC_N > 1) ? $clog2(VC_N) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_IN-1:0]          fire,
  input  logic [N_IN*VC_W-1:0]     tgt_vc,
  input  logic [N_IN*FLIT_W-1:0]   in_flit,
  output logic [VC_N-1:0]          vc_wr_en,
  output logic [VC_N*FLIT_W-1:0]   vc_wr_data
);

  logic [VC_N-1:0]        sel_en;
  logic [VC_N*FLIT_W-1:0] sel_dat;

  always_comb begin
    sel_en  = '0;
    sel_dat = '0;
    for (int v = 0; v < VC_N; v++) begin
      for (int i = 0; i < N_IN; i++) begin
        if (fire[i] && (tgt_vc[i*VC_W +: VC_W] == VC_W'(v))) begin
          sel_en[v] = 1'b1;
          sel_dat[v*FLIT_W +: FLIT_W] = in_flit[i*FLIT_W +: FLIT_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vc_wr_en   <= '0;
      vc_wr_data <= '0;
    end else begin
      vc_wr_en   <= sel_en;
      vc_wr_data <= sel_dat;
    end
  end

  for (genvar gv = 0; gv < VC_N; gv++) begin : g_chk
    p_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sel_en[gv] |=> vc_wr_en[gv]);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_en[gv] |=> !vc_wr_en[gv]);
  end

endmodule

// File: rtl/tdm_vc_xbar.sv
module tdm_vc_xbar #(
  parameter int N_IN   = 4,
  parameter int N_OUT  = 4,
  parameter int VCS    = 2,
  parameter int FLIT_W = 8,
  localparam int VC_N  = N_OUT * VCS,
  localparam int VC_W  = (VC_N > 1) ? $clog2(VC_N) : 1,
  localparam int DST_W = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_IN-1:0]          in_valid,
  input  logic [N_IN-1:0]          in_eop,
  input  logic [N_IN*DST_W-1:0]    in_dest,
  input  logic [N_IN*FLIT_W-1:0]   in_flit,
  output logic [N_IN-1:0]          in_stall,
  input  logic [VC_N-1:0]          vc_full,
  input  logic [VC_N-1:0]          vc_empty,
  output logic [VC_N-1:0]          vc_wr_en,
  output logic [VC_N*FLIT_W-1:0]   vc_wr_data
);

  logic [N_OUT*N_IN-1:0] req_mat;
  logic [N_OUT*N_IN-1:0] gnt_mat;
  logic [N_IN-1:0]       fire;
  logic [N_IN*VC_W-1:0]  tgt_vc;

  tdm_vc_coord #(.N_IN(N_IN), .N_OUT(N_OUT), .VCS(VCS)) u_coord (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_eop   (in_eop),
    .in_dest  (in_dest),
    .vc_full  (vc_full),
    .vc_empty (vc_empty),
    .fire     (fire),
    .req_mat  (req_mat),
    .tgt_vc   (tgt_vc)
  );

  for (genvar go = 0; go < N_OUT; go++) begin : g_port
    tdm_rr_arbiter #(.N(N_IN)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_mat[go*N_IN +: N_IN]),
      .gnt   (gnt_mat[go*N_IN +: N_IN])
    );
  end

  always_comb begin
    fire = '0;
    for (int o = 0; o < N_OUT; o++) fire = fire | gnt_mat[o*N_IN +: N_IN];
  end

  assign in_stall = in_valid & ~fire;

  tdm_xbar_path #(.N_IN(N_IN), .VC_N(VC_N), .FLIT_W(FLIT_W)) u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .tgt_vc     (tgt_vc),
    .in_flit    (in_flit),
    .vc_wr_en   (vc_wr_en),
    .vc_wr_data (vc_wr_data)
  );

  p_fire_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire & ~in_valid) == '0);

endmodule

// File: tb/tdm_vc_xbar_test.sv
module tdm_vc_xbar_test;
  localparam int NI = 4, NO = 4, NL = 2, NV = 8, FW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [NI-1:0]    s_valid = '0, s_eop = '0;
  logic [NI*2-1:0]  s_dest  = '0;
  logic [NI*FW-1:0] s_flit  = '0;
  logic [NV-1:0]    s_full  = '0, s_empty = '1;
  logic [NI-1:0]    stall;
  logic [NV-1:0]    wr_en;
  logic [NV*FW-1:0] wr_data;

  tdm_vc_xbar uut (
    .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .in_eop(s_eop), .in_dest(s_dest),
    .in_flit(s_flit), .in_stall(stall), .vc_full(s_full), .vc_empty(s_empty),
    .vc_wr_en(wr_en), .vc_wr_data(wr_data)
  );

  int checks = 0, failures = 0;
  bit pk_act[NI];
  int pk_len[NI], pk_pos[NI], pk_dst[NI], seq[NI];
  bit m_own[NV];
  bit m_held[NI];
  int m_hvc[NI], m_ptr[NO], e_win[NO], e_vc[NI];
  bit e_stall[NI];
  bit e_wr[NV];
  logic [FW-1:0] e_dat[NV];
  logic [NI-1:0] last_stall;

  task automatic check(input bit ok, input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic send(input int i, input int d, input int n);
    pk_act[i] = 1'b1; pk_len[i] = n; pk_pos[i] = 0; pk_dst[i] = d;
  endtask

  task automatic drive();
    for (int i = 0; i < NI; i++) begin
      s_valid[i] = pk_act[i];
      s_eop[i]   = pk_act[i] && (pk_pos[i] == pk_len[i] - 1);
      s_dest[2*i +: 2]  = 2'((pk_dst[i] + pk_pos[i]) % NO);
      s_flit[i*FW +: FW] = {2'(i), 6'(seq[i])};
    end
  endtask

  function automatic bit alloc_ok(input int v);
    return !m_own[v] && s_empty[v];
  endfunction

  task automatic model_eval();
    for (int i = 0; i < NI; i++) begin e_stall[i] = s_valid[i]; e_vc[i] = -1; end
    for (int v = 0; v < NV; v++) e_wr[v] = 1'b0;
    for (int o = 0; o < NO; o++) begin
      e_win[o] = -1;
      for (int s = 0; s < NI; s++) begin
        int i;
        i = (m_ptr[o] + s) % NI;
        if (e_win[o] < 0 && s_valid[i]) begin
          if (m_held[i]) begin
            if (m_hvc[i] / NL == o && !s_full[m_hvc[i]]) e_win[o] = i;
          end else if (int'(s_dest[2*i +: 2]) == o && (alloc_ok(o*NL) || alloc_ok(o*NL+1))) begin
            e_win[o] = i;
          end
        end
      end
      if (e_win[o] >= 0) begin
        int i, v;
        i = e_win[o];
        v = m_held[i] ? m_hvc[i] : (alloc_ok(o*NL) ? o*NL : o*NL + 1);
        e_vc[i] = v; e_stall[i] = 1'b0; e_wr[v] = 1'b1; e_dat[v] = s_flit[i*FW +: FW];
      end
    end
  endtask

  task automatic model_update();
    for (int o = 0; o < NO; o++) begin
      if (e_win[o] >= 0) begin
        int i, v;
        i = e_win[o]; v = e_vc[i];
        m_ptr[o] = (i + 1) % NI;
        if (m_held[i]) begin
          if (s_eop[i]) begin m_own[v] = 1'b0; m_held[i] = 1'b0; end
        end else if (!s_eop[i]) begin
          m_own[v] = 1'b1; m_held[i] = 1'b1; m_hvc[i] = v;
        end
      end
    end
    for (int i = 0; i < NI; i++) begin
      if (s_valid[i] && !e_stall[i]) begin
        seq[i]++; pk_pos[i]++;
        if (pk_pos[i] == pk_len[i]) pk_act[i] = 1'b0;
      end
    end
  endtask

  task automatic cyc(input string tag);
    drive();
    @(negedge clk);
    model_eval();
    last_stall = stall;
    for (int i = 0; i < NI; i++)
      check(stall[i] == e_stall[i], tag, $sformatf("in_stall[%0d]", i), stall[i], e_stall[i]);
    @(posedge clk); #1;
    for (int v = 0; v < NV; v++) begin
      check(wr_en[v] == e_wr[v], tag, $sformatf("vc_wr_en[%0d]", v), wr_en[v], e_wr[v]);
      if (e_wr[v])
        check(wr_data[v*FW +: FW] == e_dat[v], tag, $sformatf("vc_wr_data[%0d]", v), wr_data[v*FW +: FW], e_dat[v]);
    end
    model_update();
  endtask

  task automatic drain(input string tag);
    int n;
    n = 0;
    while ((pk_act[0] || pk_act[1] || pk_act[2] || pk_act[3]) && n < 200) begin
      cyc(tag); n++;
    end
    check(n < 200, tag, "drain", n, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int i = 0; i < NI; i++) begin pk_act[i] = 1'b0; m_held[i] = 1'b0; m_hvc[i] = 0; seq[i] = 0; end
    for (int v = 0; v < NV; v++) m_own[v] = 1'b0;
    for (int o = 0; o < NO; o++) m_ptr[o] = 0;
    s_full = '0; s_empty = '1;
    drive();
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check(wr_en == '0, "R1", "vc_wr_en after reset", wr_en, 0);
    check(stall == '0, "R1", "in_stall after reset", stall, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();

    // R3: header from input 1 to port 2 lands on lane 0 (channel 4)
    send(1, 2, 3);
    cyc("R3"); check(wr_en == 8'h10, "R3", "header channel", wr_en, 8'h10);
    // R4: body flits follow the lock although in_dest changes
    cyc("R4"); check(wr_en == 8'h10, "R4", "body channel", wr_en, 8'h10);
    cyc("R4"); check(wr_en == 8'h10, "R4", "tail channel", wr_en, 8'h10);
    send(1, 2, 1);
    cyc("R4"); check(wr_en == 8'h10, "R4", "channel free after tail", wr_en, 8'h10);

    // R3: a draining unowned channel is not idle, lane 1 is taken
    s_empty[4] = 1'b0;
    send(0, 2, 1);
    cyc("R3"); check(wr_en == 8'h20, "R3", "skip non-empty lane", wr_en, 8'h20);
    s_empty[5] = 1'b0;
    send(0, 2, 1);
    cyc("R5"); check(last_stall[0] == 1'b1, "R5", "no idle lane stalls", last_stall[0], 1);
    s_empty[5:4] = 2'b11;
    cyc("R5"); check(wr_en == 8'h10, "R5", "pending header granted", wr_en, 8'h10);

    // R5: two packets own both lanes of port 1, third header waits
    send(0, 1, 6); send(1, 1, 6); send(2, 1, 2);
    for (int k = 0; k < 10; k++) begin
      cyc("R5"); check(last_stall[2] == 1'b1, "R5", "third header held", last_stall[2], 1);
    end
    drain("R5");

    // R6: full owned channel blocks its owner
    send(3, 0, 4);
    cyc("R6"); check(wr_en == 8'h01, "R6", "header to channel 0", wr_en, 8'h01);
    s_full[0] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      cyc("R6");
      check(last_stall[3] == 1'b1, "R6", "busy owner stalled", last_stall[3], 1);
      check(wr_en == 8'h00, "R6", "no write to full channel", wr_en, 0);
    end
    s_full[0] = 1'b0;
    drain("R6");

    // R7: four inputs to four ports advance together
    for (int i = 0; i < NI; i++) send(i, 3 - i, 2);
    cyc("R7"); check(wr_en == 8'h55, "R7", "parallel headers", wr_en, 8'h55);
    cyc("R7"); check(wr_en == 8'h55, "R7", "parallel tails", wr_en, 8'h55);
    drain("R7");

    // R8 and R9: four inputs contend with single-flit packets on port 3
    do_reset();
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < NI; i++) if (!pk_act[i]) send(i, 3, 1);
      cyc("R8");
      check(int'(wr_data[6*FW+6 +: 2]) == k % NI, "R8", "round-robin winner", wr_data[6*FW+6 +: 2], k % NI);
      check(wr_en == 8'h40, "R9", "single-flit uses lane 0", wr_en, 8'h40);
    end
    drain("R8");

    // Sweep: random packets, lengths, destinations and queue status
    for (int k = 0; k < 3000; k++) begin
      for (int i = 0; i < NI; i++)
        if (!pk_act[i] && $urandom_range(2) == 0) send(i, int'($urandom_range(3)), 1 + int'($urandom_range(3)));
      s_full  = NV'($urandom & $urandom & $urandom);
      s_empty = ~NV'($urandom & $urandom);
      cyc("R2");
    end
    s_full = '0; s_empty = '1;
    drain("R2");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule